// File: doc/BRIEF.md
# Round-serial 64/128 Feistel block cipher engine

The engine encrypts or decrypts one 64-bit block under a 128-bit key. A single round-function datapath is reused once per clock for 44 rounds. Each round is built only from fixed rotations, bitwise AND and bitwise XOR. The round keys come from an internal four-word schedule window that advances alongside the datapath, so no round-key table is stored.

Loading a key takes 40 cycles. In that time the schedule runs forward and the last four round-key words are saved. Encryption then starts from the master key words and steps the window forward. Decryption starts from the saved words and steps the window backward, which supplies the round keys from the last one down to the first.

The host pulses `key_load` once with a new key and then issues any number of `start` pulses, each with a mode bit and a block. It waits for `done` and reads `blk_out`.

Top module: `simon_core`

## Requirements
- R1: With key words k3..k0 = 1b1a1918, 13121110, 0b0a0908, 03020100 (`key_in[31:0]` = k0), encrypting `blk_in` = 656b696c_20646e75 (`[63:32]` is the left half) yields `blk_out` = 44c8fc20_b9dfa07a.
- R2: Under the R1 key, decrypting 44c8fc20_b9dfa07a (`decrypt` = 1) yields 656b696c_20646e75.
- R3: For random keys and blocks, the encrypt result matches a round-by-round reference model, and decrypting that result returns the original block.
- R4: `done` rises exactly 44 clock edges after the edge that accepts `start`. `busy` is high from the accepting edge until `done` is asserted.
- R5: `start` and `key_load` are ignored while `busy` is high. The running operation completes with its original block and mode, and no second operation follows it.
- R6: `done` is high for exactly one cycle per completed operation.
- R7: `blk_out` holds its value from `done` until the next accepted `start`, including through a key load.
- R8: A key load keeps `busy` high for exactly 40 cycles and never raises `done`. If `key_load` and `start` are high in the same idle cycle, the key load is taken, the start is dropped, and `blk_out` is unchanged.
- R9: After synchronous reset, `busy` = 0, `done` = 0 and `blk_out` = 0.
- R10: Encryptions and decryptions may alternate under one loaded key without reloading it, and each gives the same result as it does after a fresh load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | Strobe: take `key_in` and expand it |
| key_in | input | 128 | Master key; bits [31:0] are word 0 |
| start | input | 1 | Strobe: begin one block operation |
| decrypt | input | 1 | Mode captured with `start`: 1 decrypt, 0 encrypt |
| blk_in | input | 64 | Input block; [63:32] left half |
| busy | output | 1 | Key expansion or block operation in progress |
| done | output | 1 | One-cycle pulse: `blk_out` valid |
| blk_out | output | 64 | Result block; [63:32] left half |

## Verification
Two functions can collide in one cycle. The first case is a key load and a block start raised together while the engine is idle. The second is a start or key load arriving in the middle of a running operation. The bench provokes both from directed stimulus. It then judges the outcome from the ports alone: the length of the `busy` interval, the absence of a `done` pulse, an unchanged `blk_out`, and a correct result for the original operation after the new key or block has been ignored.

// File: rtl/simon_pkg.sv
package simon_pkg;
    localparam int WORD_W       = 32;
    localparam int BLOCK_W      = 2 * WORD_W;
    localparam int KEY_WORDS    = 4;
    localparam int KEY_W        = KEY_WORDS * WORD_W;
    localparam int ROUNDS       = 44;
    localparam int EXPAND_STEPS = ROUNDS - KEY_WORDS;
    localparam int CNT_W        = $clog2(ROUNDS);
    localparam int Z_LEN        = 62;
    localparam int ZIDX_W       = $clog2(Z_LEN);

    // fixed round-constant bit sequence, first element in the MSB
    localparam logic [Z_LEN-1:0] Z_SEQ =
        62'b11011011101011000110010111100000010010001010011100110100001111;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t left;
        word_t right;
    } block_t;

    typedef word_t [KEY_WORDS-1:0] keywin_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_KEYX,
        ST_RUN
    } state_t;

    function automatic word_t rol(input word_t v, input int n);
        return (v << n) | (v >> (WORD_W - n));
    endfunction

    function automatic word_t mix(input word_t v);
        return (rol(v, 1) & rol(v, 8)) ^ rol(v, 2);
    endfunction

    function automatic logic zbit(input logic [ZIDX_W-1:0] idx);
        return Z_SEQ[Z_LEN - 1 - int'(idx)];
    endfunction

    // t = ror3(far) ^ near ; returns t ^ ror1(t)
    function automatic word_t sched_mix(input word_t near, input word_t far);
        word_t t;
        t = rol(far, WORD_W - 3) ^ near;
        return t ^ rol(t, WORD_W - 1);
    endfunction

    function automatic word_t rc(input logic z);
        return word_t'(3) ^ word_t'(z);
    endfunction
endpackage

// File: rtl/simon_round.sv
module simon_round
    import simon_pkg::*;
(
    input  block_t cur,
    input  word_t  rk,
    input  logic   dec,
    output block_t nxt
);
    always_comb begin
        if (dec) begin
            nxt.left  = cur.right;
            nxt.right = cur.left ^ mix(cur.right) ^ rk;
        end else begin
            nxt.left  = cur.right ^ mix(cur.left) ^ rk;
            nxt.right = cur.left;
        end
    end
endmodule

// File: rtl/simon_datapath.sv
module simon_datapath
    import simon_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               run,
    input  logic               dec,
    input  logic [BLOCK_W-1:0] blk_in,
    input  word_t              rk_enc,
    input  word_t              rk_dec,
    output logic [BLOCK_W-1:0] blk_out
);
    block_t data_q;
    block_t data_nxt;
    word_t  rk;

    assign rk = dec ? rk_dec : rk_enc;

    simon_round u_round (
        .cur (data_q),
        .rk  (rk),
        .dec (dec),
        .nxt (data_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (load)
            data_q <= block_t'(blk_in);
        else if (run)
            data_q <= data_nxt;
    end

    assign blk_out = data_q;

    // R7: result register untouched unless an operation loads or runs it
    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && !run) |=> $stable(blk_out));
endmodule

// File: rtl/simon_keysched.sv
module simon_keysched
    import simon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_key,
    input  logic [KEY_W-1:0]  key_in,
    input  logic              restore_enc,
    input  logic              restore_dec,
    input  logic              step_fwd,
    input  logic              step_bwd,
    input  logic              save_tail,
    input  logic [ZIDX_W-1:0] zidx,
    output word_t             rk_enc,
    output word_t             rk_dec
);
    keywin_t master_q;
    keywin_t tail_q;
    keywin_t win_q;
    keywin_t win_fwd;
    keywin_t win_bwd;

    always_comb begin
        for (int i = 0; i < KEY_WORDS - 1; i++) begin
            win_fwd[i]   = win_q[i+1];
            win_bwd[i+1] = win_q[i];
        end
        win_fwd[KEY_WORDS-1] = ~win_q[0] ^ sched_mix(win_q[1], win_q[3]) ^ rc(zbit(zidx));
        win_bwd[0] = ~(win_q[3] ^ sched_mix(win_q[0], win_q[2]) ^ rc(zbit(zidx)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            master_q <= '0;
            tail_q   <= '0;
            win_q    <= '0;
        end else begin
            if (load_key) begin
                master_q <= keywin_t'(key_in);
                win_q    <= keywin_t'(key_in);
            end else if (restore_enc)
                win_q <= master_q;
            else if (restore_dec)
                win_q <= tail_q;
            else if (step_fwd)
                win_q <= win_fwd;
            else if (step_bwd)
                win_q <= win_bwd;
            if (save_tail)
                tail_q <= win_fwd;
        end
    end

    assign rk_enc = win_q[0];
    assign rk_dec = win_q[KEY_WORDS-1];

    // R8: a single direction per cycle
    p_one_dir_r8: assert property (@(posedge clk) disable iff (rst)
        !(step_fwd && step_bwd));
endmodule

// File: rtl/simon_ctrl.sv
module simon_ctrl
    import simon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_load,
    input  logic              start,
    input  logic              decrypt,
    output logic              busy,
    output logic              done,
    output logic              ks_load,
    output logic              ks_enc,
    output logic              ks_dec,
    output logic              ks_fwd,
    output logic              ks_bwd,
    output logic              ks_save,
    output logic [ZIDX_W-1:0] zidx,
    output logic              dp_load,
    output logic              dp_run,
    output logic              dp_dec
);
    localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);
    localparam logic [CNT_W-1:0] LAST_EXP = CNT_W'(EXPAND_STEPS - 1);

    state_t           state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             mode_q;
    logic             idle;
    logic             take_key;
    logic             take_run;

    assign idle     = (state_q == ST_IDLE);
    assign take_key = idle && key_load;
    assign take_run = idle && start && !key_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (take_key)
                        state_q <= ST_KEYX;
                    else if (take_run) begin
                        state_q <= ST_RUN;
                        mode_q  <= decrypt;
                    end
                end
                ST_KEYX: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_EXP)
                        state_q <= ST_IDLE;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_RND) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = !idle;
        ks_load = take_key;
        ks_enc  = take_run && !decrypt;
        ks_dec  = take_run && decrypt;
        ks_fwd  = (state_q == ST_KEYX) || (state_q == ST_RUN && !mode_q);
        ks_bwd  = (state_q == ST_RUN) && mode_q;
        ks_save = (state_q == ST_KEYX) && (cnt_q == LAST_EXP);
        if (ks_bwd)
            zidx = (cnt_q <= LAST_EXP) ? ZIDX_W'(LAST_EXP - cnt_q) : '0;
        else
            zidx = ZIDX_W'(cnt_q);
        dp_load = take_run;
        dp_run  = (state_q == ST_RUN);
        dp_dec  = mode_q;
    end

    // R6: completion pulse lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R4: done only at the end of a block run, with busy dropped
    p_done_ends_run_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(state_q) == ST_RUN));
    // R5: a running operation is not disturbed by new strobes
    p_run_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && cnt_q != LAST_RND) |=> (state_q == ST_RUN && !done));
    // R8: key expansion never signals completion
    p_keyx_no_done_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_KEYX) |=> !done);
endmodule

// File: rtl/simon_core.sv
module simon_core
    import simon_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               key_load,
    input  logic [KEY_W-1:0]   key_in,
    input  logic               start,
    input  logic               decrypt,
    input  logic [BLOCK_W-1:0] blk_in,
    output logic               busy,
    output logic               done,
    output logic [BLOCK_W-1:0] blk_out
);
    logic              ks_load, ks_enc, ks_dec, ks_fwd, ks_bwd, ks_save;
    logic [ZIDX_W-1:0] zidx;
    logic              dp_load, dp_run, dp_dec;
    word_t             rk_enc, rk_dec;

    simon_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .key_load (key_load),
        .start    (start),
        .decrypt  (decrypt),
        .busy     (busy),
        .done     (done),
        .ks_load  (ks_load),
        .ks_enc   (ks_enc),
        .ks_dec   (ks_dec),
        .ks_fwd   (ks_fwd),
        .ks_bwd   (ks_bwd),
        .ks_save  (ks_save),
        .zidx     (zidx),
        .dp_load  (dp_load),
        .dp_run   (dp_run),
        .dp_dec   (dp_dec)
    );

    simon_keysched u_keys (
        .clk         (clk),
        .rst         (rst),
        .load_key    (ks_load),
        .key_in      (key_in),
        .restore_enc (ks_enc),
        .restore_dec (ks_dec),
        .step_fwd    (ks_fwd),
        .step_bwd    (ks_bwd),
        .save_tail   (ks_save),
        .zidx        (zidx),
        .rk_enc      (rk_enc),
        .rk_dec      (rk_dec)
    );

    simon_datapath u_data (
        .clk     (clk),
        .rst     (rst),
        .load    (dp_load),
        .run     (dp_run),
        .dec     (dp_dec),
        .blk_in  (blk_in),
        .rk_enc  (rk_enc),
        .rk_dec  (rk_dec),
        .blk_out (blk_out)
    );
endmodule

// File: tb/simon_core_tb_top.sv
`timescale 1ns/1ps
module simon_core_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         key_load = 1'b0;
    logic [127:0] key_in = '0;
    logic         start = 1'b0;
    logic         decrypt = 1'b0;
    logic [63:0]  blk_in = '0;
    logic         busy, done;
    logic [63:0]  blk_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    localparam logic [63:0] ZC = 64'h36EB_1978_1229_CD0F;

    simon_core dut_i (
        .clk(clk), .rst(rst), .key_load(key_load), .key_in(key_in),
        .start(start), .decrypt(decrypt), .blk_in(blk_in),
        .busy(busy), .done(done), .blk_out(blk_out)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired act=%0d exp<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] v, input int n);
        logic [63:0] d;
        d = {v, v};
        return d[63-n -: 32];
    endfunction

    function automatic logic [31:0] ff(input logic [31:0] v);
        return (rl(v, 1) & rl(v, 8)) ^ rl(v, 2);
    endfunction

    function automatic logic [31:0] ref_key(input logic [127:0] key, input int r);
        logic [31:0] k[48];
        logic [31:0] t;
        for (int i = 0; i < 4; i++) k[i] = key[32*i +: 32];
        for (int i = 0; i + 4 <= r; i++) begin
            t = rl(k[i+3], 29) ^ k[i+1];
            t = t ^ rl(t, 31);
            k[i+4] = k[i] ^ t ^ 32'hFFFF_FFFC ^ {31'd0, ZC[61 - (i % 62)]};
        end
        return k[r];
    endfunction

    function automatic logic [63:0] ref_enc(input logic [127:0] key, input logic [63:0] b);
        logic [31:0] x, y, t;
        x = b[63:32]; y = b[31:0];
        for (int r = 0; r < 44; r++) begin
            t = y ^ ff(x) ^ ref_key(key, r);
            y = x; x = t;
        end
        return {x, y};
    endfunction

    function automatic logic [63:0] ref_dec(input logic [127:0] key, input logic [63:0] b);
        logic [31:0] x, y, t;
        x = b[63:32]; y = b[31:0];
        for (int r = 43; r >= 0; r--) begin
            t = y;
            y = x ^ ff(y) ^ ref_key(key, r);
            x = t;
        end
        return {x, y};
    endfunction

    task automatic do_key(input logic [127:0] k, input bit with_start, output int busy_cyc, output bit saw_done);
        @(negedge clk);
        key_load = 1'b1; key_in = k;
        start = with_start; blk_in = 64'hDEAD_BEEF_0BAD_F00D; decrypt = 1'b0;
        @(posedge clk);
        @(negedge clk);
        key_load = 1'b0; start = 1'b0;
        busy_cyc = 0; saw_done = done;
        while (busy && busy_cyc < 200) begin
            @(posedge clk); @(negedge clk);
            busy_cyc++;
            if (done) saw_done = 1'b1;
        end
    endtask

    task automatic do_op(input bit dec, input logic [63:0] b, output logic [63:0] res, output int lat);
        @(negedge clk);
        start = 1'b1; decrypt = dec; blk_in = b;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(posedge clk); @(negedge clk);
            lat++;
        end
        res = blk_out;
    endtask

    localparam logic [127:0] TV_KEY = 128'h1b1a1918_13121110_0b0a0908_03020100;
    localparam logic [63:0]  TV_PT  = 64'h656b696c_20646e75;
    localparam logic [63:0]  TV_CT  = 64'h44c8fc20_b9dfa07a;

    initial begin
        int bc, lat;
        bit sd;
        logic [63:0] res, hold, r2;
        logic [127:0] rk;
        logic [63:0] rb;
        void'($urandom(32'h5EED));

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && blk_out == 64'd0, "R9 reset state", {busy, done, blk_out}, 128'd0);

        do_key(TV_KEY, 1'b0, bc, sd);
        check(bc == 40, "R8 key load busy cycles", bc, 40);
        check(!sd, "R8 key load raises no done", sd, 0);

        do_op(1'b0, TV_PT, res, lat);
        check(res == TV_CT, "R1 encrypt test vector", res, TV_CT);
        check(lat == 44, "R4 latency encrypt", lat, 44);
        @(negedge clk);
        check(!done, "R6 done single cycle", done, 0);

        do_op(1'b1, TV_CT, res, lat);
        check(res == TV_PT, "R2 decrypt test vector", res, TV_PT);
        check(lat == 44, "R4 latency decrypt", lat, 44);

        // R7: output holds while idle and across a key load
        hold = blk_out;
        repeat (5) @(negedge clk);
        check(blk_out == hold, "R7 hold while idle", blk_out, hold);
        do_key(TV_KEY ^ 128'h1, 1'b0, bc, sd);
        check(blk_out == hold, "R7 hold across key load", blk_out, hold);
        do_key(TV_KEY, 1'b0, bc, sd);

        // R5: strobes during a running encryption are ignored
        @(negedge clk);
        start = 1'b1; decrypt = 1'b0; blk_in = TV_PT;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        check(busy, "R4 busy after start", busy, 1);
        repeat (10) begin @(posedge clk); @(negedge clk); end
        start = 1'b1; decrypt = 1'b1; blk_in = 64'h0123_4567_89AB_CDEF;
        key_load = 1'b1; key_in = ~TV_KEY;
        @(posedge clk); @(negedge clk);
        start = 1'b0; key_load = 1'b0;
        lat = 11;
        while (!done && lat < 200) begin @(posedge clk); @(negedge clk); lat++; end
        check(blk_out == TV_CT && lat == 44, "R5 busy ignores strobes", blk_out, TV_CT);
        repeat (3) @(negedge clk);
        check(!busy && !done, "R5 no follow-on operation", {busy, done}, 0);
        do_op(1'b0, TV_PT, res, lat);
        check(res == TV_CT, "R5 key unchanged by ignored load", res, TV_CT);

        // R8: simultaneous key load and start in idle
        hold = blk_out;
        do_key(~TV_KEY, 1'b1, bc, sd);
        check(bc == 40, "R8 collision busy cycles", bc, 40);
        check(!sd, "R8 collision no done", sd, 0);
        check(blk_out == hold, "R8 collision output unchanged", blk_out, hold);
        do_op(1'b0, TV_PT, res, lat);
        check(res == ref_enc(~TV_KEY, TV_PT), "R8 collision key taken", res, ref_enc(~TV_KEY, TV_PT));

        // R3, R10: random keys, interleaved encrypt/decrypt without reload
        for (int n = 0; n < 6; n++) begin
            rk = {$urandom, $urandom, $urandom, $urandom};
            do_key(rk, 1'b0, bc, sd);
            for (int m = 0; m < 3; m++) begin
                rb = {$urandom, $urandom};
                do_op(1'b0, rb, res, lat);
                check(res == ref_enc(rk, rb), "R3 random encrypt", res, ref_enc(rk, rb));
                do_op(1'b1, res, r2, lat);
                check(r2 == rb, "R3 round trip", r2, rb);
                check(r2 == ref_dec(rk, res), "R3 decrypt model", r2, ref_dec(rk, res));
                do_op(1'b0, rb, r2, lat);
                check(r2 == res, "R10 re-encrypt without reload", r2, res);
            end
        end
        // corner blocks: all zeros and all ones
        do_op(1'b0, 64'd0, res, lat);
        check(res == ref_enc(rk, 64'd0), "R3 zero block", res, ref_enc(rk, 64'd0));
        do_op(1'b1, {64{1'b1}}, res, lat);
        check(res == ref_dec(rk, {64{1'b1}}), "R3 ones block decrypt", res, ref_dec(rk, {64{1'b1}}));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule